// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the synchronous address front end of a burst-capable SRAM. On every rising clock edge it samples four inputs: the external word address, an active-low chip select, and two active-low address strobes. One strobe belongs to a processor and the other to a cache controller. From these it produces the word address that the memory array uses. It also reports what kind of cycle was just taken.

A strobe loads a new base address. After that, the active-low advance input steps the two least significant address bits through a four-beat burst that wraps. A static order input picks the stepping pattern:

- Linear order adds the beat count to the base low bits, modulo 4.
- Interleaved order XORs the beat count into the base low bits.

The upper address bits never change during a burst. Bursting is optional, because a strobe can load a fresh address on every cycle with no gap. Every output is registered, so a sampled input appears at the outputs one clock after the edge that sampled it.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `word_addr_o` is 0 and `kind_o` is 0 (hold). No burst is active.
- R2: If either strobe is sampled low while `ce_n_i` is low, then after that edge `word_addr_o` equals the sampled address, `kind_o` is 1 (start), the beat count restarts at 0 and a burst becomes active.
- R3: Address bits above bit 1 change only on a start cycle. They stay fixed for the whole burst.
- R4: With `order_i` low (linear) and a burst active, an edge that samples `adv_n_i` low and both strobes high makes the low two bits of the address equal to (base low bits + beat count) mod 4. `kind_o` is then 2 (continue).
- R5: With `order_i` high (interleaved) and the same step conditions, the low two bits become (base low bits XOR beat count). `kind_o` is then 2 (continue).
- R6: An edge that samples `adv_n_i` high and both strobes high leaves `word_addr_o` unchanged, and `kind_o` is 0 (hold).
- R7: A strobe takes priority over advance. A valid strobe sampled in the middle of a burst loads the new base at once, even when `adv_n_i` is low.
- R8: If the controller strobe is sampled low while `ce_n_i` is high and the processor strobe is high, the burst ends. `kind_o` becomes 3 (deselect) and `word_addr_o` is held.
- R9: If the processor strobe is sampled low while `ce_n_i` is high, the whole cycle is ignored, whatever the controller strobe is doing. The address and burst state stay the same and `kind_o` is 0.
- R10: After four steps the low bits return to the base value, so the burst wraps inside its aligned block of four.
- R11: While no burst is active, `adv_n_i` low has no effect. The address is held and `kind_o` is 0.
- R12: Valid strobes on consecutive edges load a new address on each of them, with no penalty cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | External word address |
| ce_n_i | input | 1 | Chip select, active low |
| pstrb_n_i | input | 1 | Processor address strobe, active low |
| cstrb_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| order_i | input | 1 | Static burst order: 0 linear, 1 interleaved |
| word_addr_o | output | ADDR_W | Internal word address to the array |
| kind_o | output | 2 | Cycle taken: 0 hold, 1 start, 2 continue, 3 deselect |

## Verification
The bench first targets the wrap at the end of a burst, using bases whose low bits are not zero. A design that carries into bit 2, or that restarts from an aligned zero, gives the wrong fifth address. It then sends a strobe together with advance in the middle of a burst, and a processor strobe while chip select is high with the controller strobe also low. A wrong priority either steps the old burst or deselects a cycle that should be ignored. Finally it drives advance after a deselect and strobes on back-to-back cycles, which expose a stale active flag and a lost load.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    KIND_HOLD  = 2'd0,
    KIND_START = 2'd1,
    KIND_CONT  = 2'd2,
    KIND_DESEL = 2'd3
  } kind_e;

  typedef struct packed {
    logic load;
    logic step;
    logic desel;
  } act_t;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic pstrb_n,
  input  logic cstrb_n,
  input  logic adv_n,
  input  logic active,
  output act_t act
);

  logic any_strb;
  logic both_idle;

  always_comb begin
    any_strb  = !pstrb_n || !cstrb_n;
    both_idle = pstrb_n && cstrb_n;
    act.load  = !ce_n && any_strb;
    act.desel = ce_n && pstrb_n && !cstrb_n;
    act.step  = active && !adv_n && both_idle;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act.load, act.step, act.desel})); // R7

  AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !act.step); // R11

endmodule

// File: rtl/bseq_state.sv
module bseq_state
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_t              act,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_q,
  output logic [LOW_W-1:0]  beat_q,
  output logic              active_q,
  output kind_e             kind_q
);

  logic [ADDR_W-1:0] base_d;
  logic [LOW_W-1:0]  beat_d;
  logic              active_d;
  kind_e             kind_d;
  logic              base_en;
  logic              beat_en;
  logic              active_en;

  always_comb begin
    base_d    = base_q;
    beat_d    = beat_q;
    active_d  = active_q;
    kind_d    = KIND_HOLD;
    base_en   = 1'b0;
    beat_en   = 1'b0;
    active_en = 1'b0;
    if (act.load) begin
      base_d    = addr_i;
      beat_d    = '0;
      active_d  = 1'b1;
      kind_d    = KIND_START;
      base_en   = 1'b1;
      beat_en   = 1'b1;
      active_en = 1'b1;
    end else if (act.desel) begin
      active_d  = 1'b0;
      kind_d    = KIND_DESEL;
      active_en = 1'b1;
    end else if (act.step) begin
      beat_d  = beat_q + 1'b1;
      kind_d  = KIND_CONT;
      beat_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
      kind_q   <= KIND_HOLD;
    end else begin
      if (base_en)   base_q   <= base_d;
      if (beat_en)   beat_q   <= beat_d;
      if (active_en) active_q <= active_d;
      kind_q <= kind_d;
    end
  end

  AST_BEAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    act.load |=> (beat_q == '0) && active_q); // R2

  AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    act.desel |=> !active_q && $stable(base_q)); // R8

endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
  parameter int LOW_W = 2
) (
  input  logic [LOW_W-1:0] base_lo,
  input  logic [LOW_W-1:0] beat,
  input  logic             order_i,
  output logic [LOW_W-1:0] lo_o
);

  logic [LOW_W-1:0] lin_lo;
  logic [LOW_W-1:0] ilv_lo;

  always_comb lin_lo = base_lo + beat;

  for (genvar gi = 0; gi < LOW_W; gi++) begin : g_ilv
    assign ilv_lo[gi] = base_lo[gi] ^ beat[gi];
  end

  always_comb lo_o = order_i ? ilv_lo : lin_lo;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              pstrb_n_i,
  input  logic              cstrb_n_i,
  input  logic              adv_n_i,
  input  logic              order_i,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [1:0]        kind_o
);

  localparam int LOW_W = $clog2(BURST_LEN);

  act_t              act;
  logic [ADDR_W-1:0] base_q;
  logic [LOW_W-1:0]  beat_q;
  logic              active_q;
  kind_e             kind_q;
  logic [LOW_W-1:0]  lo;

  bseq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n_i),
    .pstrb_n (pstrb_n_i),
    .cstrb_n (cstrb_n_i),
    .adv_n   (adv_n_i),
    .active  (active_q),
    .act     (act)
  );

  bseq_state #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .addr_i   (addr_i),
    .base_q   (base_q),
    .beat_q   (beat_q),
    .active_q (active_q),
    .kind_q   (kind_q)
  );

  bseq_order #(.LOW_W(LOW_W)) u_order (
    .base_lo (base_q[LOW_W-1:0]),
    .beat    (beat_q),
    .order_i (order_i),
    .lo_o    (lo)
  );

  always_comb begin
    word_addr_o = {base_q[ADDR_W-1:LOW_W], lo};
    kind_o      = kind_q;
  end

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n_i && (!pstrb_n_i || !cstrb_n_i)) |=>
      (word_addr_o == $past(addr_i)) && (kind_o == KIND_START)); // R2

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_o != KIND_START) |->
      (word_addr_o[ADDR_W-1:LOW_W] == $past(word_addr_o[ADDR_W-1:LOW_W]))); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!order_i && active_q && !adv_n_i && pstrb_n_i && cstrb_n_i) |=>
      (word_addr_o[LOW_W-1:0] == LOW_W'($past(word_addr_o[LOW_W-1:0]) + 1'b1))); // R4

  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (pstrb_n_i && cstrb_n_i && adv_n_i) |=>
      $stable(word_addr_o) && (kind_o == KIND_HOLD)); // R6

  AST_DESEL_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n_i && pstrb_n_i && !cstrb_n_i) |=>
      (kind_o == KIND_DESEL) && $stable(word_addr_o)); // R8

  AST_PSTRB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n_i && !pstrb_n_i) |=>
      $stable(word_addr_o) && $stable(active_q) && (kind_o == KIND_HOLD)); // R9

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int AW = 20;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          ce_n_i, pstrb_n_i, cstrb_n_i, adv_n_i, order_i;
  logic [AW-1:0] word_addr_o;
  logic [1:0]    kind_o;

  int n_run;
  int n_fail;
  int cyc;

  logic [AW-1:0] m_base;
  logic [1:0]    m_beat;
  logic          m_act;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i),
    .pstrb_n_i(pstrb_n_i), .cstrb_n_i(cstrb_n_i), .adv_n_i(adv_n_i),
    .order_i(order_i), .word_addr_o(word_addr_o), .kind_o(kind_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [1:0] exp_lo(input logic [1:0] b, input logic [1:0] k,
                                        input logic ord);
    return ord ? (b ^ k) : (b + k);
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return {m_base[AW-1:2], exp_lo(m_base[1:0], m_beat, order_i)};
  endfunction

  task automatic check(input string tag, input logic [AW-1:0] ea, input logic [1:0] ek);
    n_run = n_run + 1;
    if (word_addr_o !== ea || kind_o !== ek) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual addr=%h kind=%0d expected addr=%h kind=%0d",
               tag, word_addr_o, kind_o, ea, ek);
    end
  endtask

  // drive at negedge, update model, wait one edge, check at next negedge
  task automatic cyc_step(input logic ce, input logic ps, input logic cs, input logic adv,
                          input logic [AW-1:0] a, input string force_tag);
    logic [1:0] ek;
    string      tag;
    addr_i = a; ce_n_i = ce; pstrb_n_i = ps; cstrb_n_i = cs; adv_n_i = adv;
    if (!ce && (!ps || !cs)) begin
      tag = (m_act && !adv) ? "R7" : "R2";
      m_base = a; m_beat = 2'd0; m_act = 1'b1; ek = 2'd1;
    end else if (ce && ps && !cs) begin
      tag = "R8"; m_act = 1'b0; ek = 2'd3;
    end else if (ce && !ps) begin
      tag = "R9"; ek = 2'd0;
    end else if (m_act && !adv) begin
      m_beat = m_beat + 2'd1; ek = 2'd2;
      if (m_beat == 2'd0) tag = "R10";
      else tag = order_i ? "R5/R3" : "R4/R3";
    end else if (!m_act && !adv) begin
      tag = "R11"; ek = 2'd0;
    end else begin
      tag = "R6"; ek = 2'd0;
    end
    if (force_tag != "") tag = force_tag;
    @(posedge clk);
    @(negedge clk);
    check(tag, exp_addr(), ek);
  endtask

  initial begin
    int unsigned sd;
    n_run = 0; n_fail = 0; cyc = 0;
    sd = $urandom(32'd7321);
    m_base = '0; m_beat = '0; m_act = 1'b0;
    addr_i = '0; ce_n_i = 1'b1; pstrb_n_i = 1'b1; cstrb_n_i = 1'b1;
    adv_n_i = 1'b1; order_i = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", '0, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", '0, 2'd0);

    // linear burst from low bits 2: 2,3,0,1 then wrap to 2
    order_i = 1'b0;
    cyc_step(0, 0, 1, 1, 20'hABCD2, "");
    for (int i = 0; i < 5; i++) cyc_step(0, 1, 1, 0, 20'h11111, "");
    cyc_step(0, 1, 1, 1, 20'h22222, "R6");
    // strobe with advance mid-burst aborts
    cyc_step(0, 1, 1, 0, 20'h0, "");
    cyc_step(0, 1, 0, 0, 20'h5A5A7, "R7");
    // interleaved burst from low bits 1: 1,0,3,2, wrap to 1
    order_i = 1'b1;
    cyc_step(0, 0, 1, 1, 20'h12341, "R2");
    for (int i = 0; i < 5; i++) cyc_step(0, 1, 1, 0, 20'h0, "");
    // processor strobe with chip select high, controller strobe also low
    cyc_step(1, 0, 0, 0, 20'hFFFFF, "R9");
    cyc_step(1, 0, 1, 1, 20'hEEEEE, "R9");
    // deselect then advance has no effect
    cyc_step(1, 1, 0, 0, 20'h33333, "R8");
    cyc_step(0, 1, 1, 0, 20'h44444, "R11");
    cyc_step(1, 1, 1, 0, 20'h44444, "R11");
    // back-to-back loads
    cyc_step(0, 0, 1, 0, 20'h00003, "R12");
    cyc_step(0, 1, 0, 1, 20'h80001, "R12");
    cyc_step(0, 0, 0, 0, 20'h7FFFE, "R12");

    // constrained random in both orders
    for (int ph = 0; ph < 2; ph++) begin
      order_i = ph[0];
      for (int i = 0; i < 3000; i++) begin
        logic ce, ps, cs, adv;
        ce  = ($urandom_range(0, 9) < 2);
        ps  = ($urandom_range(0, 9) != 0);
        cs  = ($urandom_range(0, 9) != 0);
        adv = ($urandom_range(0, 9) < 4);
        cyc_step(ce, ps, cs, adv, AW'($urandom), "");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule